// File: doc/BRIEF.md
# Differential I/O Line Register Slave

This block is the host-facing register slave of a 24-line differential I/O module. It sits on a 16-bit, zero-wait-state logic bus clocked by the module clock. When the I/O select is seen, it takes the word index and any write data at that same clock edge. On the next cycle it raises the acknowledge, and it keeps the acknowledge high while the host holds the cycle. An ID-space select gets the same handshake, but its read data is a constant supplied by a neighbouring block.

Four registers are served. The output latch is written and read back at one address, so a host can do read-modify-write bit operations. The direct-read input register returns the live line state, which the line datapath supplies. The per-line output-enable register is active low. The control register holds four bits: buffering, clock edge, clock source and master role. The register values go out to the line datapath as plain outputs.

Top module: `ioline_regslave`

## Requirements
- R1: After reset, the output latch is all zeros, every output-enable bit is 1, all four control bits are 0, acknowledge is low and read data is zero.
- R2: An I/O select or an ID select seen while acknowledge is low raises acknowledge on the following cycle. With no hold, acknowledge stays high for exactly one cycle. If both selects are high together, the I/O select wins.
- R3: While acknowledge is high and hold is high, acknowledge stays high on the next cycle, so a cycle held for k extra cycles is acknowledged for 1+k cycles.
- R4: Word index 0 holds lines 1–16, with line n in bit n-1. Writing index 0 loads the output latch, and reading index 0 returns the latched value.
- R5: Word index 1 holds lines 17–24 in bits 7:0, with line 17 in bit 0. At index 1 and index 5, data bits 15:8 are ignored on write and read back as zero.
- R6: Word index 2 returns input lines 1–16 and word index 3 returns input lines 17–24 in bits 7:0, from the live input value. Writes to these indices change nothing.
- R7: Word indices 4 and 5 hold the active-low output enables, laid out like indices 0 and 1. A 0 drives the line and a 1 makes it an input. The outputs show the stored value.
- R8: Word index 6 is the control register. Bit 0 is buffering enable, bit 1 is clock edge (1 = falling), bit 2 is clock-source select and bit 3 is master role. Bits 15:4 read as zero.
- R9: byte_en[0] gates data bits 7:0 and byte_en[1] gates data bits 15:8. A write with one lane off leaves that lane's register bits unchanged.
- R10: Read data is zero whenever acknowledge is low. During an acknowledged ID-select cycle, read data equals the id_data input, and an ID-select write changes no register.
- R11: Word indices 7 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | I/O-space select, active high |
| id_sel | input | 1 | ID-space select, active high |
| hold | input | 1 | Host hold request, extends acknowledge |
| write | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 6 | Word index (byte offset divided by two) |
| byte_en | input | 2 | Byte-lane enables; bit 0 for data 7:0, bit 1 for data 15:8 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero outside acknowledge |
| ack | output | 1 | Cycle acknowledge |
| id_data | input | 16 | Constant ID word from the ID block |
| din_lines | input | 24 | Input-register value from the line datapath |
| out_latch | output | 24 | Output latch value to the line drivers |
| out_en_n | output | 24 | Active-low per-line driver enables |
| dbuf_en | output | 1 | Buffering enable (control bit 0) |
| clk_pol | output | 1 | Buffer clock edge, 1 = falling (control bit 1) |
| ms_mode | output | 1 | Clock taken from line 24 when set (control bit 2) |
| master_sel | output | 1 | Module re-drives the clock as master (control bit 3) |

## Verification
A seeded random stream mixes reads and writes across all seven mapped indices and some unmapped ones. It uses random byte-lane masks, random hold lengths, and a mix of I/O and ID selects, and the live input value changes between cycles. A separate model tracks each register, so the stream can show a wrong lane mapping, a wrong bit position for lines 17–24, leaking upper bits, and writes that land in the wrong register. Directed cases cover the reset image, single-lane writes, a cycle with both selects high, and ID-space writes, which must leave every register untouched. Counting acknowledge cycles against the hold length shows whether hold is honoured, ignored, or held one cycle too long.

// File: rtl/ioline_pkg.sv
package ioline_pkg;
    localparam int IDX_W   = 6;
    localparam int BUS_W   = 16;
    localparam int CTRL_W  = 4;

    localparam logic [IDX_W-1:0] IDX_OUT_LO = 6'd0;
    localparam logic [IDX_W-1:0] IDX_OUT_HI = 6'd1;
    localparam logic [IDX_W-1:0] IDX_IN_LO  = 6'd2;
    localparam logic [IDX_W-1:0] IDX_IN_HI  = 6'd3;
    localparam logic [IDX_W-1:0] IDX_OE_LO  = 6'd4;
    localparam logic [IDX_W-1:0] IDX_OE_HI  = 6'd5;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 6'd6;

    localparam int CB_DBUF   = 0;
    localparam int CB_POL    = 1;
    localparam int CB_MSMODE = 2;
    localparam int CB_MASTER = 3;
endpackage

// File: rtl/ioline_bus_ctl.sv
module ioline_bus_ctl
    import ioline_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_sel,
    input  logic             id_sel,
    input  logic             hold,
    input  logic             write,
    input  logic [IDX_W-1:0] addr,
    output logic             ack,
    output logic             cyc_id,
    output logic [IDX_W-1:0] cyc_idx,
    output logic             wr_stb
);
    typedef struct packed {
        logic             ack;
        logic             is_id;
        logic [IDX_W-1:0] idx;
    } bus_t;

    bus_t st_d, st_q;
    logic start;

    always_comb begin
        st_d   = st_q;
        start  = !st_q.ack && (io_sel || id_sel);
        wr_stb = start && io_sel && write;
        if (start) begin
            st_d.ack   = 1'b1;
            st_d.is_id = !io_sel;
            st_d.idx   = addr;
        end else if (st_q.ack) begin
            st_d.ack = hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack     = st_q.ack;
    assign cyc_id  = st_q.is_id;
    assign cyc_idx = st_q.idx;
endmodule

// File: rtl/ioline_regs.sv
module ioline_regs
    import ioline_pkg::*;
#(
    parameter int N_LINES = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [1:0]         wr_be,
    input  logic [BUS_W-1:0]   wdata,
    output logic [N_LINES-1:0] lat,
    output logic [N_LINES-1:0] oe_n,
    output logic [CTRL_W-1:0]  ctrl
);
    localparam int HI_W = N_LINES - BUS_W;

    typedef struct packed {
        logic [N_LINES-1:0] lat;
        logic [N_LINES-1:0] oe_n;
        logic [CTRL_W-1:0]  ctrl;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                    input logic [BUS_W-1:0] new_v,
                                                    input logic [1:0]       be);
        logic [BUS_W-1:0] res;
        res = old_v;
        for (int b = 0; b < 2; b++) begin
            if (be[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return res;
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_stb) begin
            unique case (wr_idx)
                IDX_OUT_LO: r_d.lat[BUS_W-1:0]  = lane_merge(r_q.lat[BUS_W-1:0], wdata, wr_be);
                IDX_OUT_HI: if (wr_be[0]) r_d.lat[N_LINES-1:BUS_W] = wdata[HI_W-1:0];
                IDX_OE_LO:  r_d.oe_n[BUS_W-1:0] = lane_merge(r_q.oe_n[BUS_W-1:0], wdata, wr_be);
                IDX_OE_HI:  if (wr_be[0]) r_d.oe_n[N_LINES-1:BUS_W] = wdata[HI_W-1:0];
                IDX_CTRL:   if (wr_be[0]) r_d.ctrl = wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.lat  <= '0;
            r_q.oe_n <= '1;
            r_q.ctrl <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lat  = r_q.lat;
    assign oe_n = r_q.oe_n;
    assign ctrl = r_q.ctrl;
endmodule

// File: rtl/ioline_rd_mux.sv
module ioline_rd_mux
    import ioline_pkg::*;
#(
    parameter int N_LINES = 24
) (
    input  logic               ack,
    input  logic               is_id,
    input  logic [IDX_W-1:0]   idx,
    input  logic [N_LINES-1:0] lat,
    input  logic [N_LINES-1:0] oe_n,
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic [N_LINES-1:0] din,
    input  logic [BUS_W-1:0]   id_data,
    output logic [BUS_W-1:0]   rdata
);
    localparam int HI_W = N_LINES - BUS_W;
    localparam logic [BUS_W-HI_W-1:0]   HI_PAD   = '0;
    localparam logic [BUS_W-CTRL_W-1:0] CTRL_PAD = '0;

    logic [BUS_W-1:0] sel_v;

    always_comb begin
        unique case (idx)
            IDX_OUT_LO: sel_v = lat[BUS_W-1:0];
            IDX_OUT_HI: sel_v = {HI_PAD, lat[N_LINES-1:BUS_W]};
            IDX_IN_LO:  sel_v = din[BUS_W-1:0];
            IDX_IN_HI:  sel_v = {HI_PAD, din[N_LINES-1:BUS_W]};
            IDX_OE_LO:  sel_v = oe_n[BUS_W-1:0];
            IDX_OE_HI:  sel_v = {HI_PAD, oe_n[N_LINES-1:BUS_W]};
            IDX_CTRL:   sel_v = {CTRL_PAD, ctrl};
            default:    sel_v = '0;
        endcase
        if (!ack)       rdata = '0;
        else if (is_id) rdata = id_data;
        else            rdata = sel_v;
    end
endmodule

// File: rtl/ioline_regslave.sv
module ioline_regslave
    import ioline_pkg::*;
#(
    parameter int N_LINES = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_sel,
    input  logic               id_sel,
    input  logic               hold,
    input  logic               write,
    input  logic [IDX_W-1:0]   addr,
    input  logic [1:0]         byte_en,
    input  logic [BUS_W-1:0]   wdata,
    output logic [BUS_W-1:0]   rdata,
    output logic               ack,
    input  logic [BUS_W-1:0]   id_data,
    input  logic [N_LINES-1:0] din_lines,
    output logic [N_LINES-1:0] out_latch,
    output logic [N_LINES-1:0] out_en_n,
    output logic               dbuf_en,
    output logic               clk_pol,
    output logic               ms_mode,
    output logic               master_sel
);
    logic             cyc_id;
    logic [IDX_W-1:0] cyc_idx;
    logic             wr_stb;
    logic [CTRL_W-1:0] ctrl;

    ioline_bus_ctl u_bus (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .id_sel(id_sel),
        .hold(hold), .write(write), .addr(addr), .ack(ack),
        .cyc_id(cyc_id), .cyc_idx(cyc_idx), .wr_stb(wr_stb)
    );

    ioline_regs #(.N_LINES(N_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(addr),
        .wr_be(byte_en), .wdata(wdata), .lat(out_latch),
        .oe_n(out_en_n), .ctrl(ctrl)
    );

    ioline_rd_mux #(.N_LINES(N_LINES)) u_rd (
        .ack(ack), .is_id(cyc_id), .idx(cyc_idx), .lat(out_latch),
        .oe_n(out_en_n), .ctrl(ctrl), .din(din_lines),
        .id_data(id_data), .rdata(rdata)
    );

    assign dbuf_en    = ctrl[CB_DBUF];
    assign clk_pol    = ctrl[CB_POL];
    assign ms_mode    = ctrl[CB_MSMODE];
    assign master_sel = ctrl[CB_MASTER];
endmodule

// File: rtl/ioline_regslave_chk.sv
module ioline_regslave_chk #(
    parameter int N_LINES = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_sel,
    input logic               id_sel,
    input logic               hold,
    input logic               write,
    input logic               ack,
    input logic [15:0]        rdata,
    input logic [N_LINES-1:0] out_latch,
    input logic [N_LINES-1:0] out_en_n,
    input logic [3:0]         ctrl_bits
);
    assert_ack_follows_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && (io_sel || id_sel)) |=> ack);

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hold) |=> !ack);

    assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && hold) |=> ack);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !io_sel && !id_sel) |=> !ack);

    assert_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == 16'h0000));

    assert_oe_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_sel && write && !ack) |=> $stable(out_en_n));

    assert_latch_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_sel && write && !ack) |=> $stable(out_latch));

    assert_ctrl_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_sel && write && !ack) |=> $stable(ctrl_bits));
endmodule

bind ioline_regslave ioline_regslave_chk #(.N_LINES(N_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .id_sel(id_sel),
    .hold(hold), .write(write), .ack(ack), .rdata(rdata),
    .out_latch(out_latch), .out_en_n(out_en_n),
    .ctrl_bits({master_sel, ms_mode, clk_pol, dbuf_en})
);

// File: tb/ioline_regslave_tb_top.sv
module ioline_regslave_tb_top;
    localparam logic [15:0] ID_WORD = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0, id_sel = 1'b0, hold = 1'b0, write = 1'b0;
    logic [5:0]  addr = '0;
    logic [1:0]  byte_en = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack;
    logic [23:0] din_lines = '0;
    logic [23:0] out_latch, out_en_n;
    logic        dbuf_en, clk_pol, ms_mode, master_sel;

    int total = 0;
    int bad   = 0;

    logic [23:0] m_lat  = '0;
    logic [23:0] m_oe   = '1;
    logic [3:0]  m_ctrl = '0;

    always #5 clk = ~clk;

    ioline_regslave dut_i (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .id_sel(id_sel),
        .hold(hold), .write(write), .addr(addr), .byte_en(byte_en),
        .wdata(wdata), .rdata(rdata), .ack(ack), .id_data(ID_WORD),
        .din_lines(din_lines), .out_latch(out_latch), .out_en_n(out_en_n),
        .dbuf_en(dbuf_en), .clk_pol(clk_pol), .ms_mode(ms_mode),
        .master_sel(master_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic is_id, input logic [5:0] idx);
        if (is_id) return ID_WORD;
        case (idx)
            6'd0: return m_lat[15:0];
            6'd1: return {8'h00, m_lat[23:16]};
            6'd2: return din_lines[15:0];
            6'd3: return {8'h00, din_lines[23:16]};
            6'd4: return m_oe[15:0];
            6'd5: return {8'h00, m_oe[23:16]};
            6'd6: return {12'h000, m_ctrl};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                          input logic [1:0] be);
        logic [15:0] r;
        r = o;
        if (be[0]) r[7:0]  = n[7:0];
        if (be[1]) r[15:8] = n[15:8];
        return r;
    endfunction

    task automatic model_write(input logic [5:0] idx, input logic [1:0] be, input logic [15:0] wd);
        case (idx)
            6'd0: m_lat[15:0] = merge(m_lat[15:0], wd, be);
            6'd1: if (be[0]) m_lat[23:16] = wd[7:0];
            6'd4: m_oe[15:0] = merge(m_oe[15:0], wd, be);
            6'd5: if (be[0]) m_oe[23:16] = wd[7:0];
            6'd6: if (be[0]) m_ctrl = wd[3:0];
            default: ;
        endcase
    endtask

    // One bus cycle; returns first acknowledged read word and acknowledge length.
    task automatic bus(input logic s_io, input logic s_id, input logic wr,
                       input logic [5:0] idx, input logic [1:0] be, input logic [15:0] wd,
                       input int holdc, output logic [15:0] rd, output int nack);
        @(negedge clk);
        io_sel = s_io; id_sel = s_id; write = wr; addr = idx; byte_en = be; wdata = wd;
        @(negedge clk);
        io_sel = 1'b0; id_sel = 1'b0; write = 1'b0;
        rd = rdata;
        nack = 0;
        while (ack && nack < 50) begin
            hold = (nack < holdc);
            nack++;
            @(negedge clk);
        end
        hold = 1'b0;
        chk("R10 rdata zero after ack", {16'h0, rdata}, 32'h0);
        if (s_io && wr) model_write(idx, be, wd);
    endtask

    task automatic check_regs(input string req);
        chk(req, {8'h0, out_latch}, {8'h0, m_lat});
        chk(req, {8'h0, out_en_n}, {8'h0, m_oe});
        chk(req, {28'h0, master_sel, ms_mode, clk_pol, dbuf_en}, {28'h0, m_ctrl});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset image
        chk("R1 ack", {31'h0, ack}, 32'h0);
        chk("R1 rdata", {16'h0, rdata}, 32'h0);
        check_regs("R1 reset regs");

        // R4 latch write/readback, R2 single-cycle ack
        bus(1, 0, 1, 6'd0, 2'b11, 16'hBEEF, 0, rd, n);
        chk("R2 ack length", n, 1);
        bus(1, 0, 0, 6'd0, 2'b11, 16'h0, 0, rd, n);
        chk("R4 readback lines 1-16", {16'h0, rd}, {16'h0, exp_rd(0, 6'd0)});

        // R5 upper byte ignored, line 17 in bit 0
        bus(1, 0, 1, 6'd1, 2'b11, 16'hFF81, 0, rd, n);
        chk("R5 latch 17-24", {8'h0, out_latch}, 32'h0081BEEF);
        bus(1, 0, 0, 6'd1, 2'b11, 16'h0, 0, rd, n);
        chk("R5 upper zero", {16'h0, rd}, 32'h00000081);

        // R9 byte lanes
        bus(1, 0, 1, 6'd0, 2'b10, 16'h1234, 0, rd, n);
        chk("R9 high lane only", {8'h0, out_latch}, 32'h008112EF);
        bus(1, 0, 1, 6'd1, 2'b10, 16'h5555, 0, rd, n);
        chk("R9 hi word lane0 off", {8'h0, out_latch}, 32'h008112EF);

        // R7 enables, line 23 drive, line 24 input
        bus(1, 0, 1, 6'd5, 2'b01, 16'h00BF, 0, rd, n);
        chk("R7 enable 17-24", {8'h0, out_en_n}, 32'h00BFFFFF);

        // R8 control bits
        bus(1, 0, 1, 6'd6, 2'b11, 16'hFFFA, 0, rd, n);
        chk("R8 master_sel", {31'h0, master_sel}, 32'h1);
        chk("R8 ms_mode", {31'h0, ms_mode}, 32'h0);
        chk("R8 clk_pol", {31'h0, clk_pol}, 32'h1);
        bus(1, 0, 0, 6'd6, 2'b11, 16'h0, 0, rd, n);
        chk("R8 ctrl readback", {16'h0, rd}, 32'h0000000A);

        // R6 direct read
        din_lines = 24'hC3_5A96;
        bus(1, 0, 0, 6'd2, 2'b11, 16'h0, 0, rd, n);
        chk("R6 input lo", {16'h0, rd}, 32'h00005A96);
        bus(1, 0, 1, 6'd3, 2'b11, 16'hFFFF, 0, rd, n);
        check_regs("R6 write ignored");
        bus(1, 0, 0, 6'd3, 2'b11, 16'h0, 0, rd, n);
        chk("R6 input hi", {16'h0, rd}, 32'h000000C3);

        // R3 hold
        bus(1, 0, 0, 6'd4, 2'b11, 16'h0, 3, rd, n);
        chk("R3 held ack length", n, 4);

        // R10 id select, write ignored; R2 both selects -> io wins
        bus(0, 1, 1, 6'd0, 2'b11, 16'h0000, 1, rd, n);
        chk("R10 id data", {16'h0, rd}, {16'h0, ID_WORD});
        chk("R10 id ack length", n, 2);
        check_regs("R10 id write ignored");
        bus(1, 1, 0, 6'd6, 2'b11, 16'h0, 0, rd, n);
        chk("R2 io priority", {16'h0, rd}, 32'h0000000A);

        // R11 unmapped
        bus(1, 0, 1, 6'd9, 2'b11, 16'h0000, 0, rd, n);
        check_regs("R11 unmapped write");
        bus(1, 0, 0, 6'd7, 2'b11, 16'h0, 0, rd, n);
        chk("R11 unmapped read", {16'h0, rd}, 32'h0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic s_io, wr;
            logic [5:0] idx;
            logic [1:0] be;
            logic [15:0] wd, er;
            int hc;
            s_io = ($urandom % 8) != 0;
            wr   = $urandom % 2;
            idx  = 6'($urandom % 10);
            be   = 2'($urandom % 4);
            wd   = 16'($urandom);
            hc   = $urandom % 4;
            din_lines = 24'($urandom);
            er = exp_rd(!s_io, idx);
            bus(s_io, !s_io, wr, idx, be, wd, hc, rd, n);
            chk("R3 random ack length", n, hc + 1);
            if (!wr || !s_io) chk("R4 R6 R7 R10 random read", {16'h0, rd}, {16'h0, er});
            check_regs("R9 random regs");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule